// File: doc/BRIEF.md
# APB Command-Driven Bus Master

This block is a bus master for an APB3-style peripheral bus without wait states. A client hands it commands over a valid/ready port. Each command names an operation (idle, write or read), a 32-bit address, 32-bit write data and an 8-bit idle count. A write or read becomes a two-cycle transfer: a setup cycle with the select asserted, then an access cycle with the enable raised. After the transfer the bus stays idle for exactly the requested number of cycles. During those cycles the select, enable and write data drop to zero, while the address and direction keep their last values so that the bus does not toggle needlessly.

Every write or read produces one response on a second valid/ready port. The response repeats the operation and address and carries the read data, which is sampled on the clock edge that ends the access cycle. Responses go through a small in-order queue. The master takes a new command only when the queue is sure to have room for that command's response, so no response is ever dropped. With a zero idle count and a command already waiting, the next setup cycle follows the access cycle directly.

Top module: `apb_cmd_master`

## Requirements
- R1: A write (kind 2'b01) or read (kind 2'b10) accepted on a clock edge puts the bus in setup for the following cycle: psel=1, penable=0, paddr set to the command address, pwrite=1 for a write and 0 for a read, and pwdata set to the command data for a write and 0 for a read.
- R2: The cycle after setup is the access cycle. penable=1 and every other bus output is unchanged. The access cycle lasts exactly one cycle.
- R3: After an access cycle with idle count N (0 to 255), exactly N idle cycles pass before the next setup cycle when a command is already waiting. With N=0 the next setup follows the access cycle directly.
- R4: In every idle cycle psel, penable and pwdata are 0, and paddr and pwrite keep the values of the last transfer.
- R5: A command of kind 2'b00, or the unused code 2'b11, is an idle command. It takes exactly one idle bus cycle whatever its idle count, starts no transfer and produces no response.
- R6: A read response carries the prdata value present during its access cycle. A write response carries zero data.
- R7: Exactly one response is issued for each write or read, in command order, with rsp_kind and rsp_addr repeating the command's kind code and address. It becomes valid in the cycle after the access cycle.
- R8: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_kind, rsp_addr and rsp_rdata stay unchanged.
- R9: cmd_ready is low during a setup cycle, while idle cycles remain, and whenever the response queue (two entries) has no room for the command's response. It rises as soon as rsp_ready frees room.
- R10: While rst_n is low (asynchronous, active low), paddr, pwrite, psel, penable and pwdata are 0. After reset, rsp_valid is 0 and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_kind | input | 2 | 00 idle, 01 write, 10 read, 11 idle |
| cmd_addr | input | 32 | Transfer address |
| cmd_wdata | input | 32 | Write data |
| cmd_idle | input | 8 | Idle cycles after the transfer |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed on this edge when valid |
| rsp_kind | output | 2 | Kind code of the finished transfer |
| rsp_addr | output | 32 | Address of the finished transfer |
| rsp_rdata | output | 32 | Read data, zero for writes |
| paddr | output | 32 | Bus address |
| pwrite | output | 1 | Bus direction, 1 for write |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus enable |
| pwdata | output | 32 | Bus write data |
| prdata | input | 32 | Bus read data |

## Verification
A wrong idle counter shows up one cycle early or late as a shifted setup cycle. A bad sequencing state shows up within a single cycle as an enable without a setup, or as an access phase that lasts longer than one cycle. Queue pointer or occupancy errors show up as responses that come back out of order, repeated, or missing once a stall is released. A wrong admission rule shows up as cmd_ready staying high while the queue is full, which the bench sees within a few cycles of holding rsp_ready low. Read-sampling errors show up in the first read response, because the bench's slave drives a distinct filler value outside the access cycle.

// File: rtl/apb_cmd_pkg.sv
package apb_cmd_pkg;
  typedef enum logic [1:0] {
    K_IDLE  = 2'b00,
    K_WRITE = 2'b01,
    K_READ  = 2'b10,
    K_RSVD  = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'b00,
    S_SETUP  = 2'b01,
    S_ACCESS = 2'b10
  } seq_state_e;
endpackage

// File: rtl/apb_cmd_seq.sv
module apb_cmd_seq
  import apb_cmd_pkg::*;
#(
  parameter int IDLE_W   = 8,
  parameter int RQ_DEPTH = 2,
  localparam int OCC_W   = $clog2(RQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [IDLE_W-1:0] cmd_idle,
  input  logic [OCC_W-1:0]  rq_occ,
  input  logic              rq_pop,
  output logic              cmd_ready,
  output logic              start_o,
  output logic              access_o,
  output logic              clear_o,
  output logic              push_o
);
  localparam int NW = OCC_W + 2;

  seq_state_e        state_q, state_n;
  logic [IDLE_W-1:0] cnt_q, cnt_n;
  logic              is_xfer, open, room, accept;
  logic [NW-1:0]     need;

  always_comb begin
    is_xfer   = (cmd_kind_e'(cmd_kind) == K_WRITE) || (cmd_kind_e'(cmd_kind) == K_READ);
    push_o    = (state_q == S_ACCESS);
    access_o  = (state_q == S_SETUP);
    need      = NW'(rq_occ) + NW'(push_o) + NW'(1) - NW'(rq_pop);
    room      = (need <= NW'(RQ_DEPTH));
    open      = ((state_q == S_IDLE) || (state_q == S_ACCESS)) && (cnt_q == '0);
    cmd_ready = open && room;
    accept    = cmd_valid && cmd_ready;
    start_o   = accept && is_xfer;
    clear_o   = (push_o && !start_o) || (accept && !is_xfer);
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    unique case (state_q)
      S_SETUP: state_n = S_ACCESS;
      S_IDLE, S_ACCESS: begin
        if (start_o) begin
          state_n = S_SETUP;
          cnt_n   = cmd_idle;
        end else begin
          state_n = S_IDLE;
          cnt_n   = (cnt_q != '0) ? cnt_q - IDLE_W'(1) : '0;
        end
      end
      default: begin
        state_n = S_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/apb_cmd_drv.sv
module apb_cmd_drv
  import apb_cmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              access_i,
  input  logic              clear_i,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic              psel,
  output logic              penable,
  output logic [DATA_W-1:0] pwdata
);
  logic              wr;
  logic              addr_en, sel_en;
  logic [ADDR_W-1:0] paddr_n;
  logic              pwrite_n, psel_n, penable_n;
  logic [DATA_W-1:0] pwdata_n;

  always_comb begin
    wr        = (cmd_kind_e'(cmd_kind) == K_WRITE);
    addr_en   = start_i;
    sel_en    = start_i || access_i || clear_i;
    paddr_n   = cmd_addr;
    pwrite_n  = wr;
    psel_n    = psel;
    penable_n = penable;
    pwdata_n  = pwdata;
    if (start_i) begin
      psel_n    = 1'b1;
      penable_n = 1'b0;
      pwdata_n  = wr ? cmd_wdata : '0;
    end else if (access_i) begin
      penable_n = 1'b1;
    end else if (clear_i) begin
      psel_n    = 1'b0;
      penable_n = 1'b0;
      pwdata_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr  <= '0;
      pwrite <= 1'b0;
    end else if (addr_en) begin
      paddr  <= paddr_n;
      pwrite <= pwrite_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel    <= 1'b0;
      penable <= 1'b0;
      pwdata  <= '0;
    end else if (sel_en) begin
      psel    <= psel_n;
      penable <= penable_n;
      pwdata  <= pwdata_n;
    end
  end
endmodule

// File: rtl/apb_cmd_rspq.sv
module apb_cmd_rspq #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 2,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [1:0]        push_kind,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [OCC_W-1:0]  occ_o,
  output logic              pop_o
);
  logic [1:0]        ent_kind [DEPTH];
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_n, rptr_q, rptr_n;
  logic [OCC_W-1:0]  occ_q, occ_n;

  always_comb begin
    rsp_valid = (occ_q != '0);
    pop_o     = rsp_valid && rsp_ready;
    occ_o     = occ_q;
    rsp_kind  = ent_kind[rptr_q];
    rsp_addr  = ent_addr[rptr_q];
    rsp_rdata = ent_data[rptr_q];
    wptr_n    = wptr_q;
    rptr_n    = rptr_q;
    if (push_i) wptr_n = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + PTR_W'(1);
    if (pop_o)  rptr_n = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + PTR_W'(1);
    occ_n = occ_q + OCC_W'(push_i) - OCC_W'(pop_o);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && (wptr_q == PTR_W'(i))) begin
        ent_kind[i] <= push_kind;
        ent_addr[i] <= push_addr;
        ent_data[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      occ_q  <= occ_n;
    end
  end
endmodule

// File: rtl/apb_cmd_master.sv
module apb_cmd_master
  import apb_cmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDLE_W   = 8,
  parameter int RQ_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [IDLE_W-1:0] cmd_idle,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic              psel,
  output logic              penable,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata
);
  localparam int OCC_W = $clog2(RQ_DEPTH + 1);

  logic             start, access, clear, push, pop;
  logic [OCC_W-1:0] occ;
  logic [1:0]       push_kind;
  logic [DATA_W-1:0] push_data;

  assign push_kind = pwrite ? K_WRITE : K_READ;
  assign push_data = pwrite ? '0 : prdata;

  apb_cmd_seq #(.IDLE_W(IDLE_W), .RQ_DEPTH(RQ_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_idle(cmd_idle), .rq_occ(occ), .rq_pop(pop), .cmd_ready(cmd_ready),
    .start_o(start), .access_o(access), .clear_o(clear), .push_o(push)
  );

  apb_cmd_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .start_i(start), .access_i(access), .clear_i(clear),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .paddr(paddr), .pwrite(pwrite), .psel(psel), .penable(penable), .pwdata(pwdata)
  );

  apb_cmd_rspq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_kind(push_kind),
    .push_addr(paddr), .push_data(push_data), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
    .rsp_rdata(rsp_rdata), .occ_o(occ), .pop_o(pop)
  );
endmodule

// File: rtl/apb_cmd_master_chk.sv
module apb_cmd_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_kind,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] paddr,
  input logic              pwrite,
  input logic              psel,
  input logic              penable,
  input logic [DATA_W-1:0] pwdata
);
  // R2: setup is followed by access with the bus otherwise unchanged
  a_r2_setup_to_access: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  // R2: access lasts a single cycle
  a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    penable |=> !penable);

  // R1: enable only together with select
  a_r1_enable_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);

  // R1: a read drives zero write data
  a_r1_read_zero_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> (pwdata == '0));

  // R4: idle cycles clear enable and write data
  a_r4_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> (!penable && (pwdata == '0)));

  // R4: entering idle keeps address and direction
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psel) |-> ($stable(paddr) && $stable(pwrite)));

  // R9: no command is taken during a setup cycle
  a_r9_no_ready_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |-> !cmd_ready);

  // R8: a stalled response holds
  a_r8_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_addr) && $stable(rsp_rdata)));
endmodule

bind apb_cmd_master apb_cmd_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata),
  .paddr(paddr), .pwrite(pwrite), .psel(psel), .penable(penable), .pwdata(pwdata)
);

// File: tb/tb_apb_cmd_master.sv
`timescale 1ns/1ps
module tb_apb_cmd_master;
  localparam logic [31:0] KEY    = 32'h5A5A_0F0F;
  localparam logic [1:0]  KI     = 2'b00;
  localparam logic [1:0]  KW     = 2'b01;
  localparam logic [1:0]  KR     = 2'b10;
  localparam logic [1:0]  KX     = 2'b11;
  localparam int          TRN    = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'b00;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  cmd_idle = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_addr, rsp_rdata, paddr, pwdata, prdata;
  logic        pwrite, psel, penable;

  always #2 clk = ~clk;

  apb_cmd_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata), .paddr(paddr), .pwrite(pwrite),
    .psel(psel), .penable(penable), .pwdata(pwdata), .prdata(prdata)
  );

  // slave model: valid data only in the access cycle
  assign prdata = (psel && penable) ? (paddr ^ KEY) : 32'hFFFF_FFFF;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        t_sel [TRN];
  logic        t_en  [TRN];
  logic        t_wr  [TRN];
  logic [31:0] t_a   [TRN];
  logic [31:0] t_d   [TRN];
  always @(negedge clk) begin
    t_sel[cyc % TRN] <= psel;
    t_en[cyc % TRN]  <= penable;
    t_wr[cyc % TRN]  <= pwrite;
    t_a[cyc % TRN]   <= paddr;
    t_d[cyc % TRN]   <= pwdata;
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed { logic [1:0] k; logic [31:0] a; logic [31:0] d; } exp_t;
  exp_t exp_q[$];
  exp_t e_head;

  // response scoreboard (R6, R7)
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected response addr", 64'(rsp_addr), 64'h0);
      end else begin
        e_head = exp_q.pop_front();
        chk(rsp_kind == e_head.k, "R7", "rsp kind", 64'(rsp_kind), 64'(e_head.k));
        chk(rsp_addr == e_head.a, "R7", "rsp addr", 64'(rsp_addr), 64'(e_head.a));
        chk(rsp_rdata == e_head.d, "R6", "rsp data", 64'(rsp_rdata), 64'(e_head.d));
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d,
                      input logic [7:0] n, output int acc);
    cmd_kind = k; cmd_addr = a; cmd_wdata = d; cmd_idle = n; cmd_valid = 1'b1;
    while (!cmd_ready) begin
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    acc = cyc;
    cmd_valid = 1'b0;
    if (k == KW) exp_q.push_back('{k: KW, a: a, d: 32'h0});
    else if (k == KR) exp_q.push_back('{k: KR, a: a, d: a ^ KEY});
  endtask

  task automatic bus_at(input int c, input bit s, input bit en, input logic [31:0] a,
                        input bit w, input logic [31:0] d, input string req);
    int i = c % TRN;
    chk(t_sel[i] == s,  req, $sformatf("psel@%0d", c),    64'(t_sel[i]), 64'(s));
    chk(t_en[i] == en,  req, $sformatf("penable@%0d", c), 64'(t_en[i]),  64'(en));
    chk(t_a[i] == a,    req, $sformatf("paddr@%0d", c),   64'(t_a[i]),   64'(a));
    chk(t_wr[i] == w,   req, $sformatf("pwrite@%0d", c),  64'(t_wr[i]),  64'(w));
    chk(t_d[i] == d,    req, $sformatf("pwdata@%0d", c),  64'(t_d[i]),   64'(d));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(psel == 1'b0 && penable == 1'b0, "R10", "sel/en in reset", {psel, penable}, 0);
    chk(paddr == '0 && pwdata == '0 && pwrite == 1'b0, "R10", "addr/data in reset", 64'(paddr), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 64'(rsp_valid), 0);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready after reset", 64'(cmd_ready), 1);
    wait_cyc(1);
  endtask

  task automatic t_write_then_read();
    int a0, a1;
    send(KW, 32'h0000_0104, 32'hCAFE_0001, 8'd3, a0);
    send(KR, 32'h0000_0208, 32'h1111_2222, 8'd0, a1);
    wait_cyc(4);
    chk(a1 - a0 == 5, "R3", "gap with idle 3", 64'(a1 - a0), 5);
    bus_at(a0,     1, 0, 32'h0000_0104, 1, 32'hCAFE_0001, "R1");
    bus_at(a0 + 1, 1, 1, 32'h0000_0104, 1, 32'hCAFE_0001, "R2");
    for (int c = a0 + 2; c <= a0 + 4; c++) bus_at(c, 0, 0, 32'h0000_0104, 1, 32'h0, "R4");
    bus_at(a1,     1, 0, 32'h0000_0208, 0, 32'h0, "R1");
    bus_at(a1 + 1, 1, 1, 32'h0000_0208, 0, 32'h0, "R2");
    bus_at(a1 + 2, 0, 0, 32'h0000_0208, 0, 32'h0, "R4");
  endtask

  task automatic t_back_to_back();
    int a0, a1, a2;
    send(KR, 32'h0000_0310, 32'h0, 8'd0, a0);
    send(KW, 32'h0000_0314, 32'h7777_8888, 8'd0, a1);
    send(KR, 32'h0000_0314, 32'h0, 8'd0, a2);
    wait_cyc(4);
    chk(a1 - a0 == 2, "R3", "zero idle gap read->write", 64'(a1 - a0), 2);
    chk(a2 - a1 == 2, "R3", "zero idle gap write->read", 64'(a2 - a1), 2);
    bus_at(a0 + 2, 1, 0, 32'h0000_0314, 1, 32'h7777_8888, "R3");
    bus_at(a2 + 1, 1, 1, 32'h0000_0314, 0, 32'h0, "R2");
  endtask

  task automatic t_idle_cmd();
    int a0, b, c, d;
    send(KR, 32'h0000_0420, 32'h0, 8'd0, a0);
    send(KI, 32'h0000_0FF0, 32'hABCD_0000, 8'd9, b);
    send(KX, 32'h0000_0FF4, 32'hABCD_0001, 8'd5, c);
    send(KW, 32'h0000_0424, 32'h0000_5555, 8'd0, d);
    wait_cyc(5);
    chk(b - a0 == 2, "R5", "idle cmd after access", 64'(b - a0), 2);
    chk(c - b == 1, "R5", "idle cmd one cycle", 64'(c - b), 1);
    chk(d - c == 1, "R5", "code 11 one cycle", 64'(d - c), 1);
    bus_at(b, 0, 0, 32'h0000_0420, 0, 32'h0, "R5");
    bus_at(c, 0, 0, 32'h0000_0420, 0, 32'h0, "R5");
    chk(exp_q.size() == 0, "R5", "responses outstanding", 64'(exp_q.size()), 0);
    chk(rsp_valid == 1'b0, "R5", "extra response", 64'(rsp_valid), 0);
  endtask

  task automatic t_max_idle();
    int a0, a1;
    send(KW, 32'h0000_0530, 32'h0BAD_F00D, 8'd255, a0);
    send(KR, 32'h0000_0534, 32'h0, 8'd0, a1);
    wait_cyc(4);
    chk(a1 - a0 == 257, "R3", "gap with idle 255", 64'(a1 - a0), 257);
    bus_at(a1 - 1, 0, 0, 32'h0000_0530, 1, 32'h0, "R4");
  endtask

  task automatic t_backpressure();
    int a0, a1, a2, rel;
    @(posedge clk); #0.5; rsp_ready = 1'b0; #0.5;
    send(KW, 32'h0000_0640, 32'h1234_5678, 8'd0, a0);
    send(KR, 32'h0000_0644, 32'h0, 8'd0, a1);
    chk(a1 - a0 == 2, "R9", "second command with room", 64'(a1 - a0), 2);
    fork
      send(KW, 32'h0000_0648, 32'h9ABC_DEF0, 8'd0, a2);
      begin
        repeat (6) @(posedge clk);
        #1.5;
        chk(cmd_ready == 1'b0, "R9", "ready with full queue", 64'(cmd_ready), 0);
        chk(rsp_valid == 1'b1 && rsp_addr == 32'h0000_0640, "R8", "held head addr", 64'(rsp_addr), 64'h640);
        chk(rsp_kind == KW, "R8", "held head kind", 64'(rsp_kind), 64'(KW));
        repeat (3) @(posedge clk);
        #1.5;
        chk(rsp_valid == 1'b1 && rsp_addr == 32'h0000_0640, "R8", "head still held", 64'(rsp_addr), 64'h640);
        chk(cmd_ready == 1'b0, "R9", "ready still low", 64'(cmd_ready), 0);
        @(posedge clk); #0.5; rsp_ready = 1'b1;
        #0.5; rel = cyc;
      end
    join
    chk(a2 == rel + 1, "R9", "accept once room freed", 64'(a2), 64'(rel + 1));
    bus_at(a1 + 3, 0, 0, 32'h0000_0644, 0, 32'h0, "R9");
    wait_cyc(6);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write_then_read();
    t_back_to_back();
    t_idle_cmd();
    t_max_idle();
    t_backpressure();
    wait_cyc(6);
    chk(exp_q.size() == 0, "R7", "responses never returned", 64'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule